// File: doc/BRIEF.md
# Memory Device Boundary-Scan Test Port

This block is the serial test port of a memory device. A four-wire test interface (test clock, mode select, serial data in, serial data out) plus an optional asynchronous test reset walks a sixteen-state controller. That controller loads a small instruction register and then places one of three data registers between serial in and serial out. The three registers are a fixed 32-bit identification word, a single bypass bit, and a boundary register that captures the device's pin values.

The instruction set departs on purpose from the full standard. The all-zero test instruction behaves exactly like the sampling instruction and never touches the outputs. The sampling instruction has no preload stage, so passing through Update-DR changes nothing. One extra instruction scans the boundary register and also raises an override that forces the memory's data and echo-clock outputs to high impedance for as long as it stays current. Unassigned codes fall back to the bypass bit.

Top module: `memtap_port`

## Requirements
- R1: The controller follows the standard sixteen-state graph on rising `tck`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. A low `trst_n` forces Test-Logic-Reset asynchronously.
- R2: The current instruction is IDCODE (code 3'b001) after reset and on every rising edge spent in Test-Logic-Reset. A new code becomes current only on leaving Update-IR.
- R3: Capture-IR loads 3'b001 into the 3-bit instruction shift register. A Shift-IR scan therefore first returns 1, then 0, then 0, and code bit 0 is shifted in first.
- R4: Under IDCODE, Capture-DR loads the 32-bit identification parameter with its bit 0 forced to 1. It is shifted out least significant bit first.
- R5: BYPASS (3'b111) places one bit that captures 0 between `tdi` and `tdo`. Data emerges one shift later.
- R6: The all-zero code 3'b000 connects the boundary register exactly like sampling and keeps `hiz_force` low.
- R7: Under sampling (3'b100), Update-DR changes no output: `hiz_force` stays low. A later scan returns freshly captured pin values.
- R8: While 3'b010 is the current instruction, `hiz_force` is high and the boundary register is the scan path. `hiz_force` is low under every other code.
- R9: The unassigned codes 3'b011, 3'b101 and 3'b110 select the bypass bit and keep `hiz_force` low.
- R10: `tdo` and `tdo_oe` change only on falling `tck`. `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR.
- R11: Boundary bit i captures `pin_vals[i]` at Capture-DR and is the i-th bit shifted out. The boundary length is a parameter (default 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select sampled on rising tck |
| tdi | input | 1 | Serial data in |
| pin_vals | input | BSR_LEN | Device pin values captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| hiz_force | output | 1 | Forces memory data and echo clocks to high impedance |

## Verification
The hardest situation to reach from the ports is a return to Test-Logic-Reset through `tms` alone while the controller is deep inside a data scan with a non-default instruction loaded. The bench loads BYPASS, enters Shift-DR, and then holds `tms` high for five edges. A following identification scan shows that the instruction fell back to IDCODE. A second subtle case is that Update-DR under sampling must leave the override alone. The bench scans all-ones through the boundary register, passes Update-DR, and then rescans with different pin values to show that only the capture matters.

// File: rtl/memtap_pkg.sv
package memtap_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
   } tap_st_e;

   localparam int IR_W = 3;
   typedef logic [IR_W-1:0] ir_t;

   localparam ir_t OP_EXTEST = 3'b000;
   localparam ir_t OP_IDCODE = 3'b001;
   localparam ir_t OP_SAMPZ  = 3'b010;
   localparam ir_t OP_SAMPLE = 3'b100;
   localparam ir_t OP_BYPASS = 3'b111;

   typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} path_e;

endpackage

// File: rtl/memtap_fsm.sv
module memtap_fsm
   import memtap_pkg::*;
(
   input  logic    tck,
   input  logic    rst_n,
   input  logic    tms,
   output tap_st_e st
);

   tap_st_e nxt;

   always_comb begin
      unique case (st)
         ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
         ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
         ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
         ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         default:   nxt = ST_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) st <= ST_RESET;
      else        st <= nxt;
   end

endmodule

// File: rtl/memtap_ir.sv
module memtap_ir
   import memtap_pkg::*;
(
   input  logic    tck,
   input  logic    rst_n,
   input  tap_st_e st,
   input  logic    tdi,
   output ir_t     cur,
   output logic    ir_sout
);

   localparam ir_t CAP_PAT = ir_t'(2'b01);

   ir_t sh;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cur <= OP_IDCODE;
      end else begin
         unique case (st)
            ST_RESET:  cur <= OP_IDCODE;
            ST_CAP_IR: sh  <= CAP_PAT;
            ST_SH_IR:  sh  <= {tdi, sh[IR_W-1:1]};
            ST_UPD_IR: cur <= sh;
            default:   ;
         endcase
      end
   end

   assign ir_sout = sh[0];

endmodule

// File: rtl/memtap_dec.sv
module memtap_dec
   import memtap_pkg::*;
(
   input  ir_t   cur,
   output path_e path,
   output logic  hiz
);

   always_comb begin
      hiz = 1'b0;
      unique case (cur)
         OP_EXTEST, OP_SAMPLE: path = PATH_BSR;
         OP_SAMPZ: begin
            path = PATH_BSR;
            hiz  = 1'b1;
         end
         OP_IDCODE: path = PATH_ID;
         default:   path = PATH_BYP;
      endcase
   end

endmodule

// File: rtl/memtap_dr.sv
module memtap_dr
   import memtap_pkg::*;
#(
   parameter int          BSR_LEN = 16,
   parameter int          ID_W    = 32,
   parameter logic [31:0] ID_WORD = 32'h2B6D_4E10
) (
   input  logic               tck,
   input  logic               rst_n,
   input  tap_st_e            st,
   input  path_e              path,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] pins,
   output logic               dr_sout
);

   localparam logic [ID_W-1:0] ID_FIXED = {ID_WORD[ID_W-1:1], 1'b1};

   logic               byp_q;
   logic [ID_W-1:0]    id_q;
   logic [BSR_LEN-1:0] bsr_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         byp_q <= 1'b0;
         id_q  <= '0;
         bsr_q <= '0;
      end else if (st == ST_CAP_DR) begin
         byp_q <= 1'b0;
         id_q  <= ID_FIXED;
         bsr_q <= pins;
      end else if (st == ST_SH_DR) begin
         unique case (path)
            PATH_ID:  id_q  <= {tdi, id_q[ID_W-1:1]};
            PATH_BSR: bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
            default:  byp_q <= tdi;
         endcase
      end
   end

   always_comb begin
      unique case (path)
         PATH_ID:  dr_sout = id_q[0];
         PATH_BSR: dr_sout = bsr_q[0];
         default:  dr_sout = byp_q;
      endcase
   end

endmodule

// File: rtl/memtap_port.sv
module memtap_port
   import memtap_pkg::*;
#(
   parameter int          BSR_LEN  = 16,
   parameter int          ID_W     = 32,
   parameter logic [31:0] ID_WORD  = 32'h2B6D_4E10,
   parameter bit          USE_TRST = 1'b1
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tms,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] pin_vals,
   output logic               tdo,
   output logic               tdo_oe,
   output logic               hiz_force
);

   generate
      if (BSR_LEN < 2) begin : g_bad_bsr
         $error("memtap_port: BSR_LEN must be at least 2");
      end
      if (ID_W != 32) begin : g_bad_id
         $error("memtap_port: ID_W must be 32");
      end
   endgenerate

   logic rst_n;

   generate
      if (USE_TRST) begin : g_trst
         assign rst_n = trst_n;
      end else begin : g_no_trst
         assign rst_n = 1'b1;
      end
   endgenerate

   tap_st_e st;
   ir_t     cur_ir;
   path_e   path;
   logic    ir_sout;
   logic    dr_sout;

   memtap_fsm u_fsm (
      .tck   (tck),
      .rst_n (rst_n),
      .tms   (tms),
      .st    (st)
   );

   memtap_ir u_ir (
      .tck     (tck),
      .rst_n   (rst_n),
      .st      (st),
      .tdi     (tdi),
      .cur     (cur_ir),
      .ir_sout (ir_sout)
   );

   memtap_dec u_dec (
      .cur  (cur_ir),
      .path (path),
      .hiz  (hiz_force)
   );

   memtap_dr #(
      .BSR_LEN (BSR_LEN),
      .ID_W    (ID_W),
      .ID_WORD (ID_WORD)
   ) u_dr (
      .tck     (tck),
      .rst_n   (rst_n),
      .st      (st),
      .path    (path),
      .tdi     (tdi),
      .pins    (pin_vals),
      .dr_sout (dr_sout)
   );

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo    <= (st == ST_SH_IR) ? ir_sout : dr_sout;
         tdo_oe <= (st == ST_SH_IR) || (st == ST_SH_DR);
      end
   end

endmodule

// File: rtl/memtap_port_chk.sv
module memtap_port_chk
   import memtap_pkg::*;
(
   input logic    tck,
   input logic    trst_n,
   input logic    tms,
   input tap_st_e st,
   input ir_t     cur_ir,
   input logic    hiz_force,
   input logic    tdo_oe
);

   logic [2:0] ones_cnt;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)               ones_cnt <= '0;
      else if (!tms)             ones_cnt <= '0;
      else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
   end

   // R1
   a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
      (ones_cnt == 3'd5) |-> (st == ST_RESET));

   // R2
   a_r2_reset_loads_idcode: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_RESET) |=> (cur_ir == OP_IDCODE));

   // R7
   a_r7_update_dr_quiet: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_UPD_DR) |=> $stable(hiz_force));

   // R8
   a_r8_hiz_rises_on_update_ir: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(hiz_force) |-> ($past(st) == ST_UPD_IR));

   // R8
   a_r8_hiz_falls_on_update_or_reset: assert property (@(posedge tck) disable iff (!trst_n)
      $fell(hiz_force) |-> ($past(st) == ST_UPD_IR || $past(st) == ST_RESET));

   // R10
   a_r10_oe_in_shift_only: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe == (st == ST_SH_IR || st == ST_SH_DR));

endmodule

bind memtap_port memtap_port_chk u_chk (
   .tck       (tck),
   .trst_n    (trst_n),
   .tms       (tms),
   .st        (st),
   .cur_ir    (cur_ir),
   .hiz_force (hiz_force),
   .tdo_oe    (tdo_oe)
);

// File: tb/memtap_port_tb.sv
module memtap_port_tb;

   localparam int          BSR = 16;
   localparam logic [31:0] IDW = 32'h2B6D_4E10;
   localparam logic [31:0] ID_EXP = {IDW[31:1], 1'b1};

   logic           tck = 1'b0;
   logic           trst_n = 1'b0;
   logic           tms = 1'b1;
   logic           tdi = 1'b0;
   logic [BSR-1:0] pin_vals = '0;
   logic           tdo, tdo_oe, hiz_force;

   int nchk = 0;
   int nfail = 0;
   logic tdo_s, oe_s;
   logic rise_chg = 1'b0;

   always #2 tck = ~tck;

   memtap_port #(.BSR_LEN(BSR), .ID_WORD(IDW)) u_dut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .pin_vals(pin_vals), .tdo(tdo), .tdo_oe(tdo_oe), .hiz_force(hiz_force)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d);
      @(negedge tck);
      #1;
      tdo_s = tdo;
      oe_s  = tdo_oe;
      tms = m;
      tdi = d;
      @(posedge tck);
      #1;
      if (tdo !== tdo_s) rise_chg = 1'b1;
   endtask

   task automatic load_ir(input logic [2:0] code, output logic [2:0] got);
      tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < 3; i++) begin
         tick(i == 2, code[i]);
         got[i] = tdo_s;
      end
      tick(1, 0); tick(0, 0);
   endtask

   task automatic scan_dr(input int n, input logic [63:0] din,
                          output logic [63:0] dout, output logic oe_ok);
      dout = '0;
      oe_ok = 1'b1;
      tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < n; i++) begin
         tick(i == n - 1, din[i]);
         dout[i] = tdo_s;
         if (oe_s !== 1'b1) oe_ok = 1'b0;
      end
      tick(1, 0);
      if (oe_s !== 1'b0) oe_ok = 1'b0;
      tick(0, 0);
   endtask

   logic [2:0]  g3;
   logic [63:0] dout;
   logic        ok;

   task automatic t_reset;
      trst_n = 1'b0;
      tms = 1'b1;
      repeat (3) @(posedge tck);
      #1;
      chk("R10 reset oe", {63'd0, tdo_oe}, 64'd0);
      chk("R8 reset hiz", {63'd0, hiz_force}, 64'd0);
      trst_n = 1'b1;
      tick(0, 0);
   endtask

   task automatic t_idcode;
      scan_dr(32, 64'd0, dout, ok);
      chk("R2 R4 default IDCODE scan", dout, {32'd0, ID_EXP});
      chk("R10 oe only in shift", {63'd0, ok}, 64'd1);
   endtask

   task automatic t_bypass;
      logic [63:0] exp;
      load_ir(3'b111, g3);
      chk("R3 capture-IR pattern", {61'd0, g3}, 64'd1);
      scan_dr(8, 64'hA5, dout, ok);
      exp = {55'd0, 8'hA5, 1'b0} & 64'hFF;
      chk("R5 bypass one-bit delay", dout, exp);
   endtask

   task automatic t_extest;
      pin_vals = 16'hC3A5;
      load_ir(3'b000, g3);
      chk("R6 extest hiz low", {63'd0, hiz_force}, 64'd0);
      scan_dr(BSR, 64'd0, dout, ok);
      chk("R6 R11 extest captures pins", dout, {48'd0, 16'hC3A5});
   endtask

   task automatic t_sample;
      pin_vals = 16'h5A0F;
      load_ir(3'b100, g3);
      scan_dr(BSR, 64'hFFFF, dout, ok);
      chk("R11 sample captures pins", dout, {48'd0, 16'h5A0F});
      chk("R7 update-DR leaves hiz low", {63'd0, hiz_force}, 64'd0);
      pin_vals = 16'h1234;
      scan_dr(BSR, 64'd0, dout, ok);
      chk("R7 rescan gives fresh capture", dout, {48'd0, 16'h1234});
   endtask

   task automatic t_samplez;
      pin_vals = 16'hBEEF;
      load_ir(3'b010, g3);
      chk("R8 samplez hiz high", {63'd0, hiz_force}, 64'd1);
      scan_dr(BSR, 64'd0, dout, ok);
      chk("R8 samplez boundary path", dout, {48'd0, 16'hBEEF});
      chk("R8 hiz held after update-DR", {63'd0, hiz_force}, 64'd1);
      load_ir(3'b111, g3);
      chk("R8 hiz low after leaving samplez", {63'd0, hiz_force}, 64'd0);
   endtask

   task automatic t_reserved;
      logic [2:0] codes [3];
      codes[0] = 3'b011; codes[1] = 3'b101; codes[2] = 3'b110;
      for (int k = 0; k < 3; k++) begin
         load_ir(codes[k], g3);
         chk("R9 reserved hiz low", {63'd0, hiz_force}, 64'd0);
         scan_dr(4, 64'hB, dout, ok);
         chk("R9 reserved acts as bypass", dout, 64'h6);
      end
   endtask

   task automatic t_tms_reset;
      load_ir(3'b111, g3);
      tick(1, 0); tick(0, 0); tick(0, 0);
      repeat (5) tick(1, 0);
      tick(0, 0);
      scan_dr(32, 64'd0, dout, ok);
      chk("R1 R2 five tms-high edges restore IDCODE", dout, {32'd0, ID_EXP});
   endtask

   task automatic t_trst;
      load_ir(3'b111, g3);
      @(negedge tck);
      #1 trst_n = 1'b0;
      #1 trst_n = 1'b1;
      tick(0, 0);
      scan_dr(32, 64'd0, dout, ok);
      chk("R1 async trst restores IDCODE", dout, {32'd0, ID_EXP});
   endtask

   initial begin
      t_reset();
      t_idcode();
      t_bypass();
      t_extest();
      t_sample();
      t_samplez();
      t_reserved();
      t_tms_reset();
      t_trst();
      chk("R10 tdo steady across rising tck", {63'd0, rise_chg}, 64'd0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #400000;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule